// File: doc/BRIEF.md
# Codec Control-Mode Handshake Sequencer

This block brings an external audio codec from power-up into streaming operation. On a start request it holds the codec's active-low reset for a fixed time, with its data/control select line low so the codec stays in control mode. After the reset is released, it writes four control words into the transmit slots of a serial frame engine. It then enables the engine with the bit clock and frame sync driven by this side of the link.

Next comes a two-phase latch handshake. The sequencer first lines itself up to frame boundaries using the receive-frame flag. It then polls the latch bit of the received slot-0 word until that bit reads clear. Once it is clear, the sequencer sets the latch bit in transmit slot 0 and lets a fixed number of frames go out. After that it turns the engine off, gives clock ownership to the codec, raises the select line for data mode and turns the engine back on. A done flag reports that data mode has been reached. A timeout flag reports that the latch bit never cleared.

Top module: `codec_init_seq`

## Requirements
- R1: While rst_ni is low, and after it until the first start request, the outputs are: codec_rst_no = 0, data_mode_o = 0, eng_en_o = 0, clk_dir_out_o = 1, slot_we_o = 0, done_o = 0, timeout_o = 0.
- R2: The cycle after start_i is sampled high, codec_rst_no drives 0. It stays 0 for exactly (CLK_FREQ_HZ/1e6)*HOLD_US cycles and then goes to 1.
- R3: On the first cycle with codec_rst_no = 1, and the three cycles after it, slot_we_o = 1. These four writes carry slot_idx_o = 0, 1, 2, 3 with slot_data_o = 0x30B4, 0xA200, 0x0000, 0x0000.
- R4: After the fourth write, eng_en_o = 1 with clk_dir_out_o = 1 (this side drives the clocks) and data_mode_o = 0.
- R5: Before polling, the sequencer waits for rx_frame_i to be high, then low, then high again. During this wait the value of rx_slot0_i has no effect: no slot write occurs.
- R6: While polling, the sequencer does nothing while bit 10 of rx_slot0_i is 1. The cycle after that bit is sampled 0, it writes slot 0 with 0x34B4 (the first word with bit 10 set).
- R7: After that write, the engine stays enabled in control mode until tx_frame_i has gone high and then low exactly 4 times. Three such pulses are not enough.
- R8: Right after the fourth pulse there is one cycle with eng_en_o = 0, clk_dir_out_o = 0 and data_mode_o = 0. On the next cycle data_mode_o = 1, eng_en_o = 1, clk_dir_out_o = 0 and done_o = 1.
- R9: done_o stays 1, whatever the frame flags do, until start_i. Start_i restarts the sequence: done_o = 0, codec_rst_no = 0, clk_dir_out_o = 1.
- R10: If bit 10 of rx_slot0_i is still 1 when the TIMEOUT_FRAMES-th rising edge of rx_frame_i arrives during polling, then timeout_o = 1 and eng_en_o = 0. This holds until start_i, even if the bit clears later.
- R11: Slot writes never occur in data mode, and done_o and timeout_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or restart the bring-up sequence |
| rx_frame_i | input | 1 | Receive-frame status flag from the serial engine |
| tx_frame_i | input | 1 | Transmit-frame status flag from the serial engine |
| rx_slot0_i | input | 16 | Most recently received slot-0 word |
| codec_rst_no | output | 1 | Codec reset, active low |
| data_mode_o | output | 1 | Codec select line: 0 control, 1 data |
| eng_en_o | output | 1 | Serial engine enable |
| clk_dir_out_o | output | 1 | 1: engine drives bit clock and frame sync; 0: inputs |
| slot_we_o | output | 1 | Transmit slot write strobe |
| slot_idx_o | output | 2 | Transmit slot index for the write |
| slot_data_o | output | 16 | Transmit slot write data |
| done_o | output | 1 | Data mode reached |
| timeout_o | output | 1 | Latch bit never cleared within the frame limit |

## Verification
The assertions take the frame flags and rx_slot0_i to be synchronous to clk_i and stable around the clock edge. They treat start_i as a request that may arrive in any state. Frame counting relies on every high and low level of a flag lasting at least one clock cycle. The stimulus drives all inputs on the falling clock edge and holds each flag level for at least one full cycle, so every edge the block counts is one the bench intended.

// File: rtl/codec_init_pkg.sv
package codec_init_pkg;
  localparam int unsigned SLOT_W = 16;
  localparam int unsigned SLOT_N = 4;
  localparam int unsigned IDX_W  = $clog2(SLOT_N);

  localparam logic [SLOT_W-1:0] CTRL_WORD0 = 16'h30B4;
  localparam logic [SLOT_W-1:0] CTRL_WORD1 = 16'hA200;
  localparam logic [SLOT_W-1:0] CTRL_WORD2 = 16'h0000;
  localparam logic [SLOT_W-1:0] CTRL_WORD3 = 16'h0000;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HOLD,
    ST_LOAD,
    ST_SYNC_HI1,
    ST_SYNC_LO,
    ST_SYNC_HI2,
    ST_POLL,
    ST_ARM,
    ST_SEND,
    ST_STOP,
    ST_DATA,
    ST_FAIL
  } seq_state_e;
endpackage

// File: rtl/codec_init_hold_timer.sv
module codec_init_hold_timer #(
  parameter int unsigned CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= LOAD_VAL;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = run_i && !load_i && (cnt_q == '0);

  // R2: the count never leaves the loaded range
  a_r2_hold_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD_VAL);
  // R2: once the count has run down, a running timer reports done
  a_r2_done_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !load_i && $past(cnt_q) == CW'(1) && $past(run_i) && !$past(load_i) |-> done_o);
endmodule

// File: rtl/codec_init_edge_cnt.sv
module codec_init_edge_cnt #(
  parameter int unsigned LIMIT  = 4,
  parameter bit          RISING = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic sig_i,
  output logic last_o
);
  localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic          sig_q;
  logic          edge_hit;
  logic [CW-1:0] cnt_q;

  generate
    if (RISING) begin : g_rise
      assign edge_hit = sig_i && !sig_q;
    end else begin : g_fall
      assign edge_hit = !sig_i && sig_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i)                      cnt_q <= '0;
    else if (edge_hit && cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = !clr_i && edge_hit && (cnt_q == LAST);

  // R7 / R10: the frame count never runs past its limit
  a_r7_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R7 / R10: a held clear keeps the count at zero
  a_r10_clear_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> cnt_q == '0);
endmodule

// File: rtl/codec_init_slot_rom.sv
module codec_init_slot_rom
  import codec_init_pkg::*;
#(
  parameter int unsigned LATCH_BIT = 10
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              arm_i,
  output logic [SLOT_W-1:0] word_o
);
  logic [SLOT_W-1:0] base;

  always_comb begin
    unique case (idx_i)
      2'd0:    base = CTRL_WORD0;
      2'd1:    base = CTRL_WORD1;
      2'd2:    base = CTRL_WORD2;
      default: base = CTRL_WORD3;
    endcase
    word_o = base;
    if (arm_i) word_o[LATCH_BIT] = 1'b1;
  end
endmodule

// File: rtl/codec_init_seq.sv
module codec_init_seq
  import codec_init_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ    = 50_000_000,
  parameter int unsigned HOLD_US        = 50_000,
  parameter int unsigned SETTLE_FRAMES  = 4,
  parameter int unsigned TIMEOUT_FRAMES = 1024,
  parameter int unsigned LATCH_BIT      = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rx_frame_i,
  input  logic              tx_frame_i,
  input  logic [SLOT_W-1:0] rx_slot0_i,
  output logic              codec_rst_no,
  output logic              data_mode_o,
  output logic              eng_en_o,
  output logic              clk_dir_out_o,
  output logic              slot_we_o,
  output logic [IDX_W-1:0]  slot_idx_o,
  output logic [SLOT_W-1:0] slot_data_o,
  output logic              done_o,
  output logic              timeout_o
);
  localparam int unsigned HOLD_RAW    = (CLK_FREQ_HZ / 1_000_000) * HOLD_US;
  localparam int unsigned HOLD_CYCLES = (HOLD_RAW > 0) ? HOLD_RAW : 1;

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] load_idx_q, load_idx_d;
  logic             hold_done, settle_last, poll_last;

  codec_init_hold_timer #(.CYCLES(HOLD_CYCLES)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_i),
    .run_i  (state_q == ST_HOLD),
    .done_o (hold_done)
  );

  codec_init_edge_cnt #(.LIMIT(SETTLE_FRAMES), .RISING(1'b0)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q != ST_SEND),
    .sig_i  (tx_frame_i),
    .last_o (settle_last)
  );

  codec_init_edge_cnt #(.LIMIT(TIMEOUT_FRAMES), .RISING(1'b1)) u_poll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q != ST_POLL),
    .sig_i  (rx_frame_i),
    .last_o (poll_last)
  );

  codec_init_slot_rom #(.LATCH_BIT(LATCH_BIT)) u_rom (
    .idx_i  (slot_idx_o),
    .arm_i  (state_q == ST_ARM),
    .word_o (slot_data_o)
  );

  always_comb begin
    state_d    = state_q;
    load_idx_d = load_idx_q;
    if (start_i) begin
      state_d    = ST_HOLD;
      load_idx_d = '0;
    end else begin
      unique case (state_q)
        ST_HOLD:     if (hold_done) state_d = ST_LOAD;
        ST_LOAD: begin
          load_idx_d = load_idx_q + 1'b1;
          if (load_idx_q == IDX_W'(SLOT_N - 1)) state_d = ST_SYNC_HI1;
        end
        ST_SYNC_HI1: if (rx_frame_i)  state_d = ST_SYNC_LO;
        ST_SYNC_LO:  if (!rx_frame_i) state_d = ST_SYNC_HI2;
        ST_SYNC_HI2: if (rx_frame_i)  state_d = ST_POLL;
        ST_POLL: begin
          // latch clear wins over a same-cycle timeout
          if (!rx_slot0_i[LATCH_BIT]) state_d = ST_ARM;
          else if (poll_last)         state_d = ST_FAIL;
        end
        ST_ARM:      state_d = ST_SEND;
        ST_SEND:     if (settle_last) state_d = ST_STOP;
        ST_STOP:     state_d = ST_DATA;
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      load_idx_q <= '0;
    end else begin
      state_q    <= state_d;
      load_idx_q <= load_idx_d;
    end
  end

  always_comb begin
    codec_rst_no  = !(state_q inside {ST_IDLE, ST_HOLD});
    data_mode_o   = (state_q == ST_DATA);
    eng_en_o      = state_q inside {ST_SYNC_HI1, ST_SYNC_LO, ST_SYNC_HI2,
                                    ST_POLL, ST_ARM, ST_SEND, ST_DATA};
    clk_dir_out_o = !(state_q inside {ST_STOP, ST_DATA});
    slot_we_o     = state_q inside {ST_LOAD, ST_ARM};
    slot_idx_o    = (state_q == ST_ARM) ? '0 : load_idx_q;
    done_o        = (state_q == ST_DATA);
    timeout_o     = (state_q == ST_FAIL);
  end

  // R8: data mode only with the codec out of reset
  a_r8_data_needs_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_mode_o |-> codec_rst_no);
  // R8: entry to data mode follows a cycle with the engine off and clocks as inputs
  a_r8_off_before_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_mode_o) |-> $past(!eng_en_o && !clk_dir_out_o));
  // R11: slot writes only in control mode
  a_r11_write_ctrl_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_we_o |-> !data_mode_o && !done_o);
  // R11: done and timeout exclusive
  a_r11_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));
  // R9: done holds until a start request
  a_r9_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);
  // R10: timeout holds until a start request
  a_r10_timeout_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o && !start_i |=> timeout_o);
  // R2: start always puts the codec back into reset
  a_r2_start_resets_codec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !codec_rst_no);
endmodule

// File: tb/codec_init_seq_tb_top.sv
module codec_init_seq_tb_top;
  localparam int unsigned HOLD_EXP = 20;
  localparam int unsigned TO_EXP   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rx_frame = 1'b0;
  logic        tx_frame = 1'b0;
  logic [15:0] rx_slot0 = 16'h0000;
  logic        codec_rst_n, data_mode, eng_en, clk_dir_out, slot_we, done, timeout;
  logic [1:0]  slot_idx;
  logic [15:0] slot_data;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  codec_init_seq #(
    .CLK_FREQ_HZ(1_000_000), .HOLD_US(HOLD_EXP), .SETTLE_FRAMES(4),
    .TIMEOUT_FRAMES(TO_EXP), .LATCH_BIT(10)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rx_frame_i(rx_frame),
    .tx_frame_i(tx_frame), .rx_slot0_i(rx_slot0), .codec_rst_no(codec_rst_n),
    .data_mode_o(data_mode), .eng_en_o(eng_en), .clk_dir_out_o(clk_dir_out),
    .slot_we_o(slot_we), .slot_idx_o(slot_idx), .slot_data_o(slot_data),
    .done_o(done), .timeout_o(timeout)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk("R1", "rst codec_rst_n", codec_rst_n, 0);
    chk("R1", "rst data_mode", data_mode, 0);
    chk("R1", "rst eng_en", eng_en, 0);
    chk("R1", "rst clk_dir_out", clk_dir_out, 1);
    chk("R1", "rst slot_we", slot_we, 0);
    chk("R1", "rst done", done, 0);
    chk("R1", "rst timeout", timeout, 0);
    rst_n = 1'b1;
    repeat (3) step();
    chk("R1", "idle codec_rst_n", codec_rst_n, 0);
    chk("R1", "idle eng_en", eng_en, 0);
  endtask

  task automatic test_hold_and_load();
    int n = 0;
    pulse_start();
    while (codec_rst_n == 1'b0 && n < 200) begin
      n++;
      step();
    end
    chk("R2", "reset hold cycles", n, HOLD_EXP);
    for (int i = 0; i < 4; i++) begin
      logic [15:0] exp_w;
      exp_w = (i == 0) ? 16'h30B4 : (i == 1) ? 16'hA200 : 16'h0000;
      chk("R3", "load we", slot_we, 1);
      chk("R3", "load idx", slot_idx, i);
      chk("R3", "load data", slot_data, exp_w);
      chk("R3", "load eng off", eng_en, 0);
      step();
    end
    chk("R4", "engine on", eng_en, 1);
    chk("R4", "clocks driven", clk_dir_out, 1);
    chk("R4", "control mode", data_mode, 0);
  endtask

  task automatic test_handshake();
    rx_slot0 = 16'h0000;
    step(); step();
    chk("R5", "no write before rx high", slot_we, 0);
    rx_frame = 1'b1; step(); step();
    chk("R5", "no write while rx high", slot_we, 0);
    rx_frame = 1'b0; step(); step();
    chk("R5", "latch clear ignored before 2nd high", slot_we, 0);
    rx_slot0 = 16'h0400;
    rx_frame = 1'b1; step(); step();
    chk("R6", "polling holds with bit set", slot_we, 0);
    rx_frame = 1'b0; step();
    rx_frame = 1'b1; step();
    chk("R6", "still polling", slot_we, 0);
    chk("R10", "no early timeout", timeout, 0);
    rx_slot0 = 16'h0000;
    step();
    chk("R6", "arm write we", slot_we, 1);
    chk("R6", "arm write idx", slot_idx, 0);
    chk("R6", "arm write data", slot_data, 16'h34B4);
    step();
    chk("R6", "single arm write", slot_we, 0);
    for (int i = 0; i < 3; i++) begin
      tx_frame = 1'b1; step();
      tx_frame = 1'b0; step();
    end
    chk("R7", "3 frames: engine on", eng_en, 1);
    chk("R7", "3 frames: control mode", data_mode, 0);
    chk("R7", "3 frames: clocks driven", clk_dir_out, 1);
    tx_frame = 1'b1; step();
    tx_frame = 1'b0; step();
    chk("R8", "stop eng_en", eng_en, 0);
    chk("R8", "stop clk_dir_out", clk_dir_out, 0);
    chk("R8", "stop data_mode", data_mode, 0);
    chk("R8", "stop done", done, 0);
    step();
    chk("R8", "data data_mode", data_mode, 1);
    chk("R8", "data eng_en", eng_en, 1);
    chk("R8", "data clk_dir_out", clk_dir_out, 0);
    chk("R8", "data done", done, 1);
  endtask

  task automatic test_done_and_restart();
    for (int i = 0; i < 4; i++) begin
      rx_frame = ~rx_frame; tx_frame = ~tx_frame; rx_slot0 = 16'h0400;
      step();
    end
    chk("R9", "done sticky", done, 1);
    chk("R9", "data mode sticky", data_mode, 1);
    chk("R11", "no write in data mode", slot_we, 0);
    rx_frame = 1'b0; tx_frame = 1'b0;
    pulse_start();
    chk("R9", "restart done", done, 0);
    chk("R9", "restart codec_rst_n", codec_rst_n, 0);
    chk("R9", "restart clk_dir_out", clk_dir_out, 1);
  endtask

  task automatic test_timeout();
    int n = 0;
    rx_slot0 = 16'h0400;
    while (codec_rst_n == 1'b0 && n < 200) begin
      n++;
      step();
    end
    repeat (4) step();
    rx_frame = 1'b1; step();
    rx_frame = 1'b0; step();
    rx_frame = 1'b1; step();
    for (int i = 0; i < TO_EXP - 1; i++) begin
      rx_frame = 1'b0; step();
      rx_frame = 1'b1; step();
    end
    chk("R10", "one frame short", timeout, 0);
    chk("R10", "engine still on", eng_en, 1);
    rx_frame = 1'b0; step();
    rx_frame = 1'b1; step();
    chk("R10", "timeout set", timeout, 1);
    chk("R10", "engine off", eng_en, 0);
    chk("R11", "timeout without done", done, 0);
    rx_slot0 = 16'h0000;
    repeat (3) step();
    chk("R10", "timeout sticky", timeout, 1);
    chk("R10", "late clear ignored", slot_we, 0);
    pulse_start();
    chk("R10", "start clears timeout", timeout, 0);
  endtask

  initial begin
    repeat (100_000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_hold_and_load();
    test_handshake();
    test_done_and_restart();
    test_timeout();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule